// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block performs the sixteen two-operand data-processing operations of a 32-bit integer core: bitwise logic, moves, addition and subtraction (with carry-in and reversed-operand variants), and four compare/test operations that only produce flags. It takes the first operand from a register. The second operand is either a value that an external shifter has already shifted, or an immediate that the block builds itself from an 8-bit constant and a 4-bit rotate field. The current carry and overflow flags feed the carry-in and the unchanged-overflow paths.

A single execute strobe issues one operation. One clock later, the block presents the registered result with its write enable. It also presents the next N, Z, C, V flag vector with its own write enable. When the flag enable is low, the flag output repeats the flags that were supplied, so a downstream status register can load it unconditionally.

Top module: `dp_alu`

## Requirements
- R1: Logic opcodes: 0000 gives op1 AND op2, 0001 gives op1 XOR op2, 1100 gives op1 OR op2, 1101 gives op2, 1110 gives op1 AND NOT op2, 1111 gives NOT op2.
- R2: Arithmetic opcodes: 0100 gives op1+op2, 0101 gives op1+op2+C, 0010 gives op1-op2, 0011 gives op2-op1, 0110 gives op1-op2-(NOT C), 0111 gives op2-op1-(NOT C).
- R3: Opcodes 1000 (AND test), 1001 (XOR test), 1010 (subtract compare) and 1011 (add compare) never raise the result write enable and always raise the flag write enable, whatever the S input is.
- R4: For the twelve other opcodes, the result write enable is raised on every issued operation and the flag write enable follows S. When flags are not written, the flag output equals the flag input.
- R5: The flag vector is {N,Z,C,V} on bits 3..0. N is bit 31 of the result and Z is set exactly when the 32-bit result is zero.
- R6: On additions, C is the unsigned carry out of bit 31. On subtractions, C is 1 when no borrow occurs and 0 when one does.
- R7: On additions and subtractions, V is set exactly when the signed result cannot be represented in 32 bits.
- R8: On logic, move and test opcodes, C comes from the operand-2 carry source and V keeps its input value.
- R9: With the immediate select high, op2 is immField[7:0] rotated right by 2*immField[11:8]. The carry source is then bit 31 of that value when the rotate is nonzero, and the shifter carry input when it is zero. With the select low, op2 is the register operand and the carry source is the shifter carry input.
- R10: Outputs appear on the clock edge after the one that samples the execute strobe high. An edge with the strobe low leaves both write enables low at the next output.
- R11: Reset, which is asynchronous and active low, clears the result, the flag output and both write enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| execEn | input | 1 | Issue one operation this cycle |
| opcode | input | 4 | Operation select |
| setFlags | input | 1 | S bit: request flag update |
| immSel | input | 1 | Build op2 from immField instead of op2Reg |
| op1 | input | 32 | First operand |
| op2Reg | input | 32 | Pre-shifted second operand |
| immField | input | 12 | Rotate (11:8) and 8-bit constant (7:0) |
| shiftCarry | input | 1 | Carry out of the external shifter |
| flagsIn | input | 4 | Current {N,Z,C,V} |
| result | output | 32 | Registered result |
| resultWe | output | 1 | Result write enable |
| flagsOut | output | 4 | Next {N,Z,C,V} |
| flagWe | output | 1 | Flag write enable |

## Verification
The bench targets the carry edges. A subtraction of equal operands must give C=1 and Z=1, so a design that treats C as a borrow reports the opposite. Subtract-with-carry with C clear must take one more off the result. The 0x7FFFFFFF+1 and 0x80000000-1 cases separate a correct overflow from one computed on the uninverted operand. Compare and test operations issued with S=0 must still write flags and must not write the result. Immediate cases with zero and nonzero rotate show whether the carry comes from the right source and whether the rotate amount was doubled.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } aluOp_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cinSel_e;

  typedef enum logic [2:0] {LG_AND, LG_EOR, LG_ORR, LG_PASS, LG_BIC, LG_INV} logicSel_e;

  typedef struct packed {
    logic      isArith;
    logic      swapOps;
    logic      invB;
    cinSel_e   cinSel;
    logicSel_e logicSel;
    logic      writeResult;
    logic      writeFlags;
  } aluCtrl_t;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       setFlags,
  output aluCtrl_t   ctrl
);

  aluOp_e op;
  assign op = aluOp_e'(opcode);

  always_comb begin
    ctrl             = '0;
    ctrl.cinSel      = CIN_ZERO;
    ctrl.logicSel    = LG_AND;
    ctrl.writeResult = 1'b1;
    ctrl.writeFlags  = setFlags;
    case (op)
      OP_AND: ctrl.logicSel = LG_AND;
      OP_EOR: ctrl.logicSel = LG_EOR;
      OP_ORR: ctrl.logicSel = LG_ORR;
      OP_MOV: ctrl.logicSel = LG_PASS;
      OP_BIC: ctrl.logicSel = LG_BIC;
      OP_MVN: ctrl.logicSel = LG_INV;
      OP_ADD: ctrl.isArith = 1'b1;
      OP_ADC: begin ctrl.isArith = 1'b1; ctrl.cinSel = CIN_FLAG; end
      OP_SUB: begin ctrl.isArith = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE; end
      OP_SBC: begin ctrl.isArith = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_FLAG; end
      OP_RSB: begin
        ctrl.isArith = 1'b1; ctrl.swapOps = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE;
      end
      OP_RSC: begin
        ctrl.isArith = 1'b1; ctrl.swapOps = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_FLAG;
      end
      OP_TST: begin
        ctrl.logicSel = LG_AND; ctrl.writeResult = 1'b0; ctrl.writeFlags = 1'b1;
      end
      OP_TEQ: begin
        ctrl.logicSel = LG_EOR; ctrl.writeResult = 1'b0; ctrl.writeFlags = 1'b1;
      end
      OP_CMP: begin
        ctrl.isArith = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE;
        ctrl.writeResult = 1'b0; ctrl.writeFlags = 1'b1;
      end
      OP_CMN: begin
        ctrl.isArith = 1'b1; ctrl.writeResult = 1'b0; ctrl.writeFlags = 1'b1;
      end
      default: ctrl.logicSel = LG_AND;
    endcase
  end

endmodule

// File: rtl/dp_alu_imm.sv
module dp_alu_imm #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W+ROT_W-1:0] field,
  input  logic                   carryIn,
  output logic [DATA_W-1:0]      value,
  output logic                   carryOut
);

  localparam int FIELD_W = IMM_W + ROT_W;

  logic [DATA_W-1:0]   ext;
  logic [ROT_W:0]      amount;
  logic [2*DATA_W-1:0] doubled;

  assign ext     = DATA_W'(field[IMM_W-1:0]);
  assign amount  = {field[FIELD_W-1:IMM_W], 1'b0};
  assign doubled = {ext, ext} >> amount;
  assign value   = doubled[DATA_W-1:0];

  // A zero rotate leaves the carry source to the shifter; otherwise the top bit.
  assign carryOut = (field[FIELD_W-1:IMM_W] == '0) ? carryIn : value[DATA_W-1];

endmodule

// File: rtl/dp_alu_path.sv
module dp_alu_path
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  aluCtrl_t                 ctrl,
  input  logic [DATA_W-1:0]        op1,
  input  logic [DATA_W-1:0]        op2Reg,
  input  logic                     immSel,
  input  logic [IMM_W+ROT_W-1:0]   immField,
  input  logic                     shiftCarry,
  input  logic                     carryFlag,
  input  logic                     ovfFlag,
  output logic [DATA_W-1:0]        res,
  output logic [3:0]               nextFlags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] immVal, op2, opA, opBRaw, opB, logicRes, sum;
  logic              immCarry, logicCarry, cin, cout, ovf;
  logic [DATA_W:0]   wide;

  dp_alu_imm #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .field(immField), .carryIn(shiftCarry), .value(immVal), .carryOut(immCarry)
  );

  assign op2        = immSel ? immVal : op2Reg;
  assign logicCarry = immSel ? immCarry : shiftCarry;

  // Adder path
  assign opA    = ctrl.swapOps ? op2 : op1;
  assign opBRaw = ctrl.swapOps ? op1 : op2;
  assign opB    = ctrl.invB ? ~opBRaw : opBRaw;

  always_comb begin
    case (ctrl.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = carryFlag;
      default:  cin = 1'b0;
    endcase
  end

  assign wide = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, cin};
  assign sum  = wide[DATA_W-1:0];
  assign cout = wide[DATA_W];
  assign ovf  = (opA[MSB] == opB[MSB]) && (sum[MSB] != opA[MSB]);

  // Logic path
  always_comb begin
    case (ctrl.logicSel)
      LG_AND:  logicRes = op1 & op2;
      LG_EOR:  logicRes = op1 ^ op2;
      LG_ORR:  logicRes = op1 | op2;
      LG_PASS: logicRes = op2;
      LG_BIC:  logicRes = op1 & ~op2;
      LG_INV:  logicRes = ~op2;
      default: logicRes = op1 & op2;
    endcase
  end

  assign res = ctrl.isArith ? sum : logicRes;

  always_comb begin
    nextFlags         = '0;
    nextFlags[FLAG_N] = res[MSB];
    nextFlags[FLAG_Z] = (res == '0);
    nextFlags[FLAG_C] = ctrl.isArith ? cout : logicCarry;
    nextFlags[FLAG_V] = ctrl.isArith ? ovf : ovfFlag;
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   execEn,
  input  logic [3:0]             opcode,
  input  logic                   setFlags,
  input  logic                   immSel,
  input  logic [DATA_W-1:0]      op1,
  input  logic [DATA_W-1:0]      op2Reg,
  input  logic [IMM_W+ROT_W-1:0] immField,
  input  logic                   shiftCarry,
  input  logic [3:0]             flagsIn,
  output logic [DATA_W-1:0]      result,
  output logic                   resultWe,
  output logic [3:0]             flagsOut,
  output logic                   flagWe
);

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] res;
  logic [3:0]        nextFlags;

  dp_alu_ctrl u_ctrl (.opcode(opcode), .setFlags(setFlags), .ctrl(ctrl));

  dp_alu_path #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_path (
    .ctrl(ctrl), .op1(op1), .op2Reg(op2Reg), .immSel(immSel), .immField(immField),
    .shiftCarry(shiftCarry), .carryFlag(flagsIn[FLAG_C]), .ovfFlag(flagsIn[FLAG_V]),
    .res(res), .nextFlags(nextFlags)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      resultWe <= 1'b0;
      flagsOut <= '0;
      flagWe   <= 1'b0;
    end else begin
      resultWe <= execEn & ctrl.writeResult;
      flagWe   <= execEn & ctrl.writeFlags;
      if (execEn) begin
        result   <= res;
        flagsOut <= ctrl.writeFlags ? nextFlags : flagsIn;
      end
    end
  end

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              execEn,
  input logic [3:0]        opcode,
  input logic              setFlags,
  input logic [3:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic [3:0]        flagsOut,
  input logic              flagWe
);

  logic isCompare;
  logic isLogic;
  assign isCompare = (opcode[3:2] == 2'b10);
  assign isLogic   = (opcode[3:2] == 2'b11) || (opcode[3:1] == 3'b000) || (opcode[3:1] == 3'b100);

  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && execEn && isCompare) |-> !resultWe); // R3

  AST_COMPARE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && execEn && isCompare) |-> flagWe); // R3

  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && execEn && !isCompare && !setFlags) |-> (!flagWe && resultWe && flagsOut == $past(flagsIn))); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |-> (flagsOut[2] == (result == '0))); // R5

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |-> (flagsOut[3] == result[DATA_W-1])); // R5

  AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && execEn && isLogic && (setFlags || isCompare)) |-> (flagsOut[0] == $past(flagsIn[0]))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && !execEn) |-> (!resultWe && !flagWe)); // R10

endmodule

bind dp_alu dp_alu_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .execEn(execEn), .opcode(opcode), .setFlags(setFlags),
  .flagsIn(flagsIn), .result(result), .resultWe(resultWe), .flagsOut(flagsOut), .flagWe(flagWe)
);

// File: tb/dp_alu_test.sv
module dp_alu_test;

  typedef struct {
    logic [31:0] res;
    bit          rwe;
    logic [3:0]  fl;
    bit          fwe;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execEn = 1'b0;
  logic [3:0]  opcode = '0;
  logic        setFlags = 1'b0;
  logic        immSel = 1'b0;
  logic [31:0] op1 = '0;
  logic [31:0] op2Reg = '0;
  logic [11:0] immField = '0;
  logic        shiftCarry = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic [31:0] result;
  logic        resultWe;
  logic [3:0]  flagsOut;
  logic        flagWe;

  int checks = 0;
  int fails = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  item_t sb[$];

  always #5 clk = ~clk;

  dp_alu uut (
    .clk(clk), .rstN(rstN), .execEn(execEn), .opcode(opcode), .setFlags(setFlags),
    .immSel(immSel), .op1(op1), .op2Reg(op2Reg), .immField(immField),
    .shiftCarry(shiftCarry), .flagsIn(flagsIn), .result(result), .resultWe(resultWe),
    .flagsOut(flagsOut), .flagWe(flagWe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expandImm(input logic [11:0] f);
    logic [31:0] v = {24'b0, f[7:0]};
    for (int i = 0; i < 2 * f[11:8]; i++) v = {v[0], v[31:1]};
    return v;
  endfunction

  function automatic bit sOvf(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // Expected outcome from the requirements (R1..R9)
  function automatic item_t model(input logic [3:0] op, input bit s, input bit im,
      input logic [31:0] a, input logic [31:0] b, input logic [11:0] f,
      input bit sc, input logic [3:0] fl, input string tag);
    item_t it;
    logic [31:0] o2, x, y, r;
    bit c, v, lc, arith, cin;
    o2 = im ? expandImm(f) : b;
    lc = (im && f[11:8] != 0) ? o2[31] : sc;
    c = fl[1]; v = fl[0]; arith = 1'b0; r = '0;
    case (op)
      4'h0, 4'h8: r = a & o2;
      4'h1, 4'h9: r = a ^ o2;
      4'hC: r = a | o2;
      4'hD: r = o2;
      4'hE: r = a & ~o2;
      4'hF: r = ~o2;
      default: arith = 1'b1;
    endcase
    if (arith) begin
      if (op == 4'h4 || op == 4'h5 || op == 4'hB) begin
        cin = (op == 4'h5) ? fl[1] : 1'b0;
        r = a + o2 + 32'(cin);
        c = (longint'(a) + longint'(o2) + longint'(cin)) > 64'h0FFFFFFFF;
        v = sOvf(longint'($signed(a)) + longint'($signed(o2)) + longint'(cin));
      end else begin
        bit bor;
        bor = (op == 4'h6 || op == 4'h7) ? !fl[1] : 1'b0;
        x = (op == 4'h3 || op == 4'h7) ? o2 : a;
        y = (op == 4'h3 || op == 4'h7) ? a : o2;
        r = x - y - 32'(bor);
        c = longint'(x) >= longint'(y) + longint'(bor);
        v = sOvf(longint'($signed(x)) - longint'($signed(y)) - longint'(bor));
      end
    end else begin
      c = lc;
    end
    it.res = r;
    it.rwe = (op[3:2] != 2'b10);
    it.fwe = (op[3:2] == 2'b10) ? 1'b1 : s;
    it.fl  = it.fwe ? {r[31], (r == 0), c, v} : fl;
    it.tag = tag;
    return it;
  endfunction

  task automatic drive(input logic [3:0] op, input bit s, input bit im,
      input logic [31:0] a, input logic [31:0] b, input logic [11:0] f,
      input bit sc, input logic [3:0] fl, input string tag);
    @(negedge clk);
    execEn = 1'b1; opcode = op; setFlags = s; immSel = im; op1 = a; op2Reg = b;
    immField = f; shiftCarry = sc; flagsIn = fl;
    sb.push_back(model(op, s, im, a, b, f, sc, fl, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    execEn = 1'b0;
  endtask

  // Monitor: scoreboard compare one cycle after issue
  initial begin
    forever begin
      @(posedge clk);
      if (monOn) begin
        bit issued;
        issued = execEn;
        #1;
        if (issued && sb.size() > 0) begin
          item_t e;
          e = sb.pop_front();
          chk(resultWe == e.rwe, e.tag, "resultWe", 32'(resultWe), 32'(e.rwe));
          if (e.rwe) chk(result == e.res, e.tag, "result", result, e.res);
          chk(flagWe == e.fwe, e.tag, "flagWe", 32'(flagWe), 32'(e.fwe));
          chk(flagsOut == e.fl, e.tag, "flagsOut", 32'(flagsOut), 32'(e.fl));
        end else if (!issued) begin
          chk(!resultWe && !flagWe, "R10", "idle enables", {30'b0, resultWe, flagWe}, 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(result == 0 && flagsOut == 0 && !resultWe && !flagWe, "R11", "reset state",
        {result[27:0], flagsOut} | {30'b0, resultWe, flagWe}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); monOn = 1'b1;

    // R1 logic ops
    drive(4'h0, 1, 0, 32'hF0F0_1234, 32'h0FF0_00FF, 0, 1, 4'b0001, "R1 and");
    drive(4'h1, 1, 0, 32'hFFFF_0000, 32'h0F0F_0F0F, 0, 0, 4'b0000, "R1 eor");
    drive(4'hC, 0, 0, 32'h0000_0003, 32'h8000_0000, 0, 0, 4'b1010, "R1 orr");
    drive(4'hD, 1, 0, 32'h1234_5678, 32'h0000_0000, 0, 1, 4'b0000, "R1 mov zero");
    drive(4'hE, 1, 0, 32'hFFFF_FFFF, 32'h0000_000B, 0, 0, 4'b0001, "R8 bic keeps V");
    drive(4'hF, 1, 0, 32'h0, 32'h0000_0004, 0, 0, 4'b0000, "R1 mvn");
    // R2 / R6 / R7 arithmetic corners
    drive(4'h4, 1, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, 4'b0000, "R7 add overflow");
    drive(4'h4, 1, 0, 32'hFFFF_FFFF, 32'h1, 0, 0, 4'b0000, "R6 add carry");
    drive(4'h2, 1, 0, 32'h5, 32'h5, 0, 0, 4'b0000, "R6 sub equal");
    drive(4'h2, 1, 0, 32'h0, 32'h1, 0, 0, 4'b0010, "R6 sub borrow");
    drive(4'h2, 1, 0, 32'h8000_0000, 32'h1, 0, 0, 4'b0000, "R7 sub overflow");
    drive(4'h3, 1, 0, 32'h1, 32'h100, 0, 0, 4'b0000, "R2 rsb");
    drive(4'h5, 1, 0, 32'h1, 32'hFF, 0, 0, 4'b0010, "R2 adc carry in");
    drive(4'h6, 1, 0, 32'h10, 32'h3, 0, 0, 4'b0000, "R2 sbc C clear");
    drive(4'h6, 1, 0, 32'h10, 32'h3, 0, 0, 4'b0010, "R2 sbc C set");
    drive(4'h7, 1, 0, 32'h3, 32'h10, 0, 0, 4'b0000, "R2 rsc C clear");
    // R3 compares with S clear
    drive(4'hA, 0, 0, 32'd50, 32'd50, 0, 0, 4'b0000, "R3 cmp");
    drive(4'hB, 0, 0, 32'h1, 32'hFFFF_FFFF, 0, 0, 4'b0000, "R3 cmn");
    drive(4'h8, 0, 0, 32'h2, 32'h1, 0, 1, 4'b0001, "R3 tst");
    drive(4'h9, 0, 0, 32'hA5A5, 32'hA5A5, 0, 0, 4'b1111, "R3 teq");
    // R4 no flag write
    drive(4'h4, 0, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, 4'b0110, "R4 add no S");
    idle();
    idle();
    // R9 immediates
    drive(4'hD, 1, 1, 32'h0, 32'hDEAD_BEEF, 12'hC01, 1, 4'b0000, "R9 imm 256");
    drive(4'hD, 1, 1, 32'h0, 32'h0, 12'h1FF, 0, 4'b0000, "R9 imm rot1 carry");
    drive(4'hD, 1, 1, 32'h0, 32'h0, 12'h080, 1, 4'b0000, "R9 imm rot0 carry");
    drive(4'h4, 1, 1, 32'h10, 32'h0, 12'hC01, 0, 4'b0000, "R9 add imm");
    // mixed sweep
    for (int i = 0; i < 40; i++)
      drive(4'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom,
            12'($urandom), 1'($urandom), 4'($urandom), "R5 sweep");
    idle();
    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule